// File: doc/BRIEF.md
# Indirect Extended Register Access Sequencer

This block reaches a 16-bit extended address space that is only visible through a handful of 8-bit direct registers. A command gives an operation (read or write), a 16-bit address and, for writes, one data byte. The block turns that command into a series of direct-register requests on a generic request port. It then polls a control register until the far side reports the operation finished. For reads, it finally fetches the data byte from the value register.

Polling is paced by a programmable wait measured in clock cycles and bounded by a retry budget. When the budget runs out, or when any direct request reports an error, the operation ends with an error flag. The serial bus that carries the direct requests, and any read-modify-write policy built on top, belong to other blocks.

Top module: `xra_seq`

## Requirements
- R1: A write command issues four direct writes in this order: register 0x1B with the data byte, 0x1C with address bits 15:8, 0x1D with address bits 7:0, then 0x1E with control code 0x02.
- R2: A read command issues three direct writes in this order: 0x1C with address bits 15:8, 0x1D with address bits 7:0, then 0x1E with code 0x01. After completion it issues one direct read of 0x1B, and the byte returned is presented on `cmd_rdata` with `cmd_done`.
- R3: The first direct read of 0x1E follows the control write immediately. A returned value of 0x00 marks the operation complete.
- R4: When a poll returns nonzero, the next poll is issued after WAIT_CYCLES idle cycles. With `rq_ready` held high, consecutive poll handshakes are exactly WAIT_CYCLES+1 cycles apart.
- R5: At most POLL_LIMIT polls are issued. If all of them return nonzero, the operation ends with `cmd_error` set, and no read of 0x1B is issued.
- R6: A request is accepted in the cycle where `rq_valid` and `rq_ready` are both high. While `rq_valid` is high and `rq_ready` is low, `rq_write`, `rq_addr` and `rq_wdata` hold steady. `rs_rdata` and `rs_err` are taken in the accepting cycle.
- R7: `rs_err` high in any accepting cycle ends the operation at once. No further request is issued, and the operation finishes with `cmd_error` set.
- R8: `cmd_done` is high for exactly one cycle per accepted command. `cmd_error` and `cmd_rdata` are valid in that cycle and hold until the next completion. `cmd_rdata` is 0x00 after a write or after an error.
- R9: `cmd_start` is ignored while an operation is in progress. Starts are accepted again from the cycle in which `cmd_done` is high.
- R10: After reset, `cmd_done`, `cmd_error`, `cmd_rdata` and `rq_valid` are all zero.
- R11: A write with `cmd_verify` high uses control code 0x03 (both low bits set) instead of 0x02. Everything else in the write sequence is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | Start an operation (taken only when idle) |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_verify | input | 1 | Write with verify (control code 0x03) |
| cmd_addr | input | EAW | Extended address |
| cmd_wdata | input | DW | Data byte for writes |
| cmd_done | output | 1 | One-cycle completion pulse |
| cmd_error | output | 1 | Operation failed (valid with done, held) |
| cmd_rdata | output | DW | Byte read (valid with done, held) |
| rq_valid | output | 1 | Direct request pending |
| rq_ready | input | 1 | Direct request accepted this cycle |
| rq_write | output | 1 | Direct request is a write |
| rq_addr | output | RAW | Direct register address |
| rq_wdata | output | DW | Direct write data |
| rs_rdata | input | DW | Direct read data, valid in the accepting cycle |
| rs_err | input | 1 | Direct request failed, valid in the accepting cycle |

## Verification
The hardest cases to reach are those at the edge of the retry budget. These are an operation whose control register clears on the very last permitted poll, and one where it never clears. The bench's model of the far side holds the control register nonzero for a programmed number of polls. It sweeps that number from zero to beyond POLL_LIMIT, for both reads and writes, with and without random back-pressure on `rq_ready`. A second sweep injects `rs_err` at every handshake position in turn, so that an abort is exercised from each step of the sequence.

// File: rtl/xra_pkg.sv
package xra_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_SEND,
    S_POLL,
    S_PAUSE,
    S_FETCH
  } state_t;

  typedef enum logic [1:0] {
    STEP_VAL,
    STEP_HI,
    STEP_LO,
    STEP_CTRL
  } step_t;
endpackage

// File: rtl/xra_step_mux.sv
module xra_step_mux
  import xra_pkg::*;
#(
  parameter int DW = 8,
  parameter int RAW = 8,
  parameter logic [RAW-1:0] REG_VALUE = 8'h1B,
  parameter logic [RAW-1:0] REG_AHI = 8'h1C,
  parameter logic [RAW-1:0] REG_ALO = 8'h1D,
  parameter logic [RAW-1:0] REG_CTRL = 8'h1E
) (
  input  step_t            step,
  input  logic [2*DW-1:0]  ext_addr,
  input  logic [DW-1:0]    ext_data,
  input  logic [DW-1:0]    ctrl_code,
  output logic [RAW-1:0]   o_addr,
  output logic [DW-1:0]    o_data
);
  always_comb begin
    unique case (step)
      STEP_VAL:  begin o_addr = REG_VALUE; o_data = ext_data;            end
      STEP_HI:   begin o_addr = REG_AHI;   o_data = ext_addr[2*DW-1:DW]; end
      STEP_LO:   begin o_addr = REG_ALO;   o_data = ext_addr[DW-1:0];    end
      default:   begin o_addr = REG_CTRL;  o_data = ctrl_code;           end
    endcase
  end
endmodule

// File: rtl/xra_pace_timer.sv
module xra_pace_timer #(
  parameter int WAIT_CYCLES = 1000000
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expire
);
  localparam int CW = $clog2(WAIT_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(WAIT_CYCLES - 1);

  logic [CW-1:0] cnt;

  assign expire = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run || expire) cnt <= '0;
    else                       cnt <= cnt + 1'b1;
  end

  p_wait_range_r4: assert property (@(posedge clk) disable iff (rst)
    cnt < CW'(WAIT_CYCLES));
  p_wait_restart_r4: assert property (@(posedge clk) disable iff (rst)
    expire |=> cnt == '0);
endmodule

// File: rtl/xra_poll_budget.sv
module xra_poll_budget #(
  parameter int POLL_LIMIT = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic last
);
  localparam int BW = $clog2(POLL_LIMIT + 1);

  logic [BW-1:0] used;

  assign last = (used == BW'(POLL_LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst || clr) used <= '0;
    else if (inc)   used <= used + 1'b1;
  end

  p_budget_bound_r5: assert property (@(posedge clk) disable iff (rst)
    used <= BW'(POLL_LIMIT));
endmodule

// File: rtl/xra_seq.sv
module xra_seq
  import xra_pkg::*;
#(
  parameter int DW = 8,
  parameter int EAW = 2 * DW,
  parameter int RAW = 8,
  parameter int WAIT_CYCLES = 1000000,
  parameter int POLL_LIMIT = 5,
  parameter logic [RAW-1:0] REG_VALUE = 8'h1B,
  parameter logic [RAW-1:0] REG_AHI = 8'h1C,
  parameter logic [RAW-1:0] REG_ALO = 8'h1D,
  parameter logic [RAW-1:0] REG_CTRL = 8'h1E,
  parameter logic [DW-1:0] CODE_RD = 8'h01,
  parameter logic [DW-1:0] CODE_WR = 8'h02,
  parameter logic [DW-1:0] CODE_WV = 8'h03
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cmd_start,
  input  logic            cmd_write,
  input  logic            cmd_verify,
  input  logic [EAW-1:0]  cmd_addr,
  input  logic [DW-1:0]   cmd_wdata,
  output logic            cmd_done,
  output logic            cmd_error,
  output logic [DW-1:0]   cmd_rdata,
  output logic            rq_valid,
  input  logic            rq_ready,
  output logic            rq_write,
  output logic [RAW-1:0]  rq_addr,
  output logic [DW-1:0]   rq_wdata,
  input  logic [DW-1:0]   rs_rdata,
  input  logic            rs_err
);
  state_t           state;
  step_t            step;
  logic             op_wr;
  logic [EAW-1:0]   op_addr;
  logic [DW-1:0]    op_data;
  logic [DW-1:0]    op_ctrl;
  logic             done_q, err_q;
  logic [DW-1:0]    rdata_q;
  logic [RAW-1:0]   mux_addr;
  logic [DW-1:0]    mux_data;
  logic             hs, pace_expire, budget_last;

  xra_step_mux #(
    .DW(DW), .RAW(RAW), .REG_VALUE(REG_VALUE), .REG_AHI(REG_AHI),
    .REG_ALO(REG_ALO), .REG_CTRL(REG_CTRL)
  ) u_mux (
    .step(step), .ext_addr(op_addr), .ext_data(op_data),
    .ctrl_code(op_ctrl), .o_addr(mux_addr), .o_data(mux_data)
  );

  xra_pace_timer #(.WAIT_CYCLES(WAIT_CYCLES)) u_pace (
    .clk(clk), .rst(rst), .run(state == S_PAUSE), .expire(pace_expire)
  );

  xra_poll_budget #(.POLL_LIMIT(POLL_LIMIT)) u_budget (
    .clk(clk), .rst(rst), .clr(state == S_IDLE),
    .inc(state == S_POLL && hs), .last(budget_last)
  );

  // Request fields come straight from state registers, so they are
  // stable while a request waits for ready.
  assign rq_valid = (state == S_SEND) || (state == S_POLL) || (state == S_FETCH);
  assign rq_write = (state == S_SEND);
  assign rq_addr  = (state == S_SEND) ? mux_addr :
                    (state == S_POLL) ? REG_CTRL : REG_VALUE;
  assign rq_wdata = (state == S_SEND) ? mux_data : '0;
  assign hs       = rq_valid && rq_ready;

  assign cmd_done  = done_q;
  assign cmd_error = err_q;
  assign cmd_rdata = rdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      step    <= STEP_VAL;
      op_wr   <= 1'b0;
      op_addr <= '0;
      op_data <= '0;
      op_ctrl <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        S_IDLE: if (cmd_start) begin
          op_wr   <= cmd_write;
          op_addr <= cmd_addr;
          op_data <= cmd_wdata;
          step    <= cmd_write ? STEP_VAL : STEP_HI;
          op_ctrl <= !cmd_write ? CODE_RD : (cmd_verify ? CODE_WV : CODE_WR);
          state   <= S_SEND;
        end
        S_SEND: if (hs) begin
          if (rs_err) begin
            done_q <= 1'b1; err_q <= 1'b1; rdata_q <= '0; state <= S_IDLE;
          end else if (step == STEP_CTRL) begin
            state <= S_POLL;
          end else begin
            step <= step_t'(step + 2'd1);
          end
        end
        S_POLL: if (hs) begin
          if (rs_err) begin
            done_q <= 1'b1; err_q <= 1'b1; rdata_q <= '0; state <= S_IDLE;
          end else if (rs_rdata == '0) begin
            if (op_wr) begin
              done_q <= 1'b1; err_q <= 1'b0; rdata_q <= '0; state <= S_IDLE;
            end else begin
              state <= S_FETCH;
            end
          end else if (budget_last) begin
            done_q <= 1'b1; err_q <= 1'b1; rdata_q <= '0; state <= S_IDLE;
          end else begin
            state <= S_PAUSE;
          end
        end
        S_PAUSE: if (pace_expire) state <= S_POLL;
        S_FETCH: if (hs) begin
          done_q  <= 1'b1;
          err_q   <= rs_err;
          rdata_q <= rs_err ? '0 : rs_rdata;
          state   <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    cmd_done |=> !cmd_done);
  p_req_hold_r6: assert property (@(posedge clk) disable iff (rst)
    rq_valid && !rq_ready |=> rq_valid && $stable(rq_addr) &&
                              $stable(rq_wdata) && $stable(rq_write));
  p_quiet_on_done_r7: assert property (@(posedge clk) disable iff (rst)
    cmd_done |-> !rq_valid);
  p_busy_ignore_r9: assert property (@(posedge clk) disable iff (rst)
    (state != S_IDLE) && cmd_start |=> $stable(op_addr) && $stable(op_wr));
  p_ctrl_code_r1: assert property (@(posedge clk) disable iff (rst)
    rq_valid && rq_write && rq_addr == REG_CTRL |->
      (rq_wdata == CODE_RD || rq_wdata == CODE_WR || rq_wdata == CODE_WV));
  p_fetch_after_zero_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(rq_valid && !rq_write && rq_addr == REG_VALUE) |->
      $past(rq_addr) == REG_CTRL && $past(rs_rdata) == '0);
endmodule

// File: tb/tb_xra_seq.sv
`timescale 1ns/1ps
module tb_xra_seq;
  localparam int DW = 8;
  localparam int W = 4;
  localparam int LIM = 5;

  logic clk = 1'b0, rst = 1'b1;
  logic cmd_start = 0, cmd_write = 0, cmd_verify = 0;
  logic [15:0] cmd_addr = '0;
  logic [7:0] cmd_wdata = '0;
  logic cmd_done, cmd_error, rq_valid, rq_write;
  logic [7:0] cmd_rdata, rq_addr, rq_wdata, rs_rdata;
  logic rq_ready = 1'b1;
  logic rs_err;

  int n_chk = 0, n_bad = 0;

  xra_seq #(.WAIT_CYCLES(W), .POLL_LIMIT(LIM)) dut (
    .clk(clk), .rst(rst), .cmd_start(cmd_start), .cmd_write(cmd_write),
    .cmd_verify(cmd_verify), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .cmd_done(cmd_done), .cmd_error(cmd_error), .cmd_rdata(cmd_rdata),
    .rq_valid(rq_valid), .rq_ready(rq_ready), .rq_write(rq_write),
    .rq_addr(rq_addr), .rq_wdata(rq_wdata), .rs_rdata(rs_rdata), .rs_err(rs_err)
  );

  always #2.5 clk = ~clk;

  // far-side model
  int pend = 0, pend_cfg = 0, hs_count = 0, err_at = -1;
  bit stall = 0;
  logic [7:0] m_hi = 0, m_lo = 0;
  logic [15:0] lfsr = 16'hACE1;

  function automatic logic [7:0] vfun(input logic [15:0] a);
    return a[15:8] ^ {a[6:0], a[7]} ^ 8'h3C;
  endfunction

  assign rs_rdata = (rq_addr == 8'h1E) ? ((pend > 0) ? 8'h02 : 8'h00) :
                    (rq_addr == 8'h1B) ? vfun({m_hi, m_lo}) : 8'hEE;
  assign rs_err = (hs_count == err_at);

  // log of accepted requests
  bit lg_wr[64];
  logic [7:0] lg_addr[64], lg_data[64];
  int lg_cyc[64];
  int n_log = 0, cyc = 0, n_done = 0, dbl = 0, hold_bad = 0;
  bit d_err, prev_done = 0, prev_wait = 0;
  logic [7:0] d_rdata, p_addr, p_data;

  initial forever begin
    bit hs_now, h_wr;
    logic [7:0] h_addr, h_data;
    @(negedge clk);
    cyc++;
    hs_now = !rst && rq_valid && rq_ready;
    h_wr = rq_write; h_addr = rq_addr; h_data = rq_wdata;
    if (prev_wait && rq_valid && (rq_addr != p_addr || rq_wdata != p_data)) hold_bad++;
    prev_wait = rq_valid && !rq_ready;
    p_addr = rq_addr; p_data = rq_wdata;
    if (hs_now && n_log < 64) begin
      lg_wr[n_log] = h_wr; lg_addr[n_log] = h_addr;
      lg_data[n_log] = h_data; lg_cyc[n_log] = cyc; n_log++;
    end
    if (cmd_done) begin
      n_done++; d_err = cmd_error; d_rdata = cmd_rdata;
      if (prev_done) dbl++;
    end
    prev_done = cmd_done;
    @(posedge clk); #1;
    if (hs_now) begin
      hs_count++;
      if (h_wr && h_addr == 8'h1C) m_hi = h_data;
      if (h_wr && h_addr == 8'h1D) m_lo = h_data;
      if (h_wr && h_addr == 8'h1E) pend = pend_cfg;
      if (!h_wr && h_addr == 8'h1E && pend > 0) pend--;
    end
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    rq_ready = stall ? lfsr[0] : 1'b1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_op(input bit wr, input bit vf, input logic [15:0] a,
                        input logic [7:0] d, input int p, input bit st,
                        input int ek, input int restart_at);
    bit e_wr[16];
    logic [7:0] e_addr[16], e_data[16];
    int ne = 0, np, k = 0, bad_i = -1, lastp = -1;
    bit timeout, exp_err, seq_ok = 1, gap_ok = 1;
    logic [7:0] exp_rd;
    string tag;
    tag = (ek >= 0) ? "R7" : (p >= LIM) ? "R5" : st ? "R6" : vf ? "R11" :
          (p == 0) ? "R3" : wr ? "R1" : "R2";
    if (restart_at >= 0) tag = "R9";
    if (wr) begin
      e_wr[ne] = 1; e_addr[ne] = 8'h1B; e_data[ne] = d; ne++;
    end
    e_wr[ne] = 1; e_addr[ne] = 8'h1C; e_data[ne] = a[15:8]; ne++;
    e_wr[ne] = 1; e_addr[ne] = 8'h1D; e_data[ne] = a[7:0]; ne++;
    e_wr[ne] = 1; e_addr[ne] = 8'h1E; e_data[ne] = !wr ? 8'h01 : vf ? 8'h03 : 8'h02; ne++;
    timeout = (p >= LIM);
    np = timeout ? LIM : p + 1;
    for (int i = 0; i < np; i++) begin
      e_wr[ne] = 0; e_addr[ne] = 8'h1E; e_data[ne] = 0; ne++;
    end
    if (!wr && !timeout) begin
      e_wr[ne] = 0; e_addr[ne] = 8'h1B; e_data[ne] = 0; ne++;
    end
    exp_err = timeout;
    exp_rd = (wr || timeout) ? 8'h00 : vfun(a);
    if (ek >= 0 && ek < ne) begin
      ne = ek + 1; exp_err = 1; exp_rd = 0;
    end
    @(negedge clk); #1;
    pend_cfg = p; stall = st; err_at = ek; hs_count = 0;
    n_log = 0; n_done = 0; dbl = 0; hold_bad = 0;
    cmd_start = 1; cmd_write = wr; cmd_verify = vf; cmd_addr = a; cmd_wdata = d;
    @(negedge clk); #1;
    cmd_start = 0;
    while (n_done == 0 && k < 500) begin
      @(negedge clk); #1; k++;
      cmd_start = (k == restart_at);
      cmd_write = ~wr; cmd_addr = ~a;
    end
    cmd_start = 0;
    repeat (3) @(negedge clk);
    #1;
    chk(n_done == 1, tag, "done pulses", n_done, 1);
    chk(dbl == 0, "R8", "done wider than one cycle", dbl, 0);
    for (int i = 0; i < ne; i++)
      if (bad_i < 0 && (i >= n_log || lg_wr[i] != e_wr[i] || lg_addr[i] != e_addr[i] ||
                        (e_wr[i] && lg_data[i] != e_data[i]))) bad_i = i;
    if (bad_i < 0 && n_log != ne) bad_i = ne;
    seq_ok = (bad_i < 0);
    if (!seq_ok && bad_i < n_log && bad_i < ne)
      chk(0, tag, "request addr at mismatch", lg_addr[bad_i], e_addr[bad_i]);
    else chk(seq_ok, tag, "request count", n_log, ne);
    chk(d_err == exp_err, tag, "error flag", d_err, exp_err);
    chk(d_rdata == exp_rd, (wr ? "R8" : "R2"), "read data", d_rdata, exp_rd);
    chk(cmd_error == d_err && cmd_rdata == d_rdata, "R8", "results held", cmd_rdata, d_rdata);
    chk(hold_bad == 0, "R6", "request changed while stalled", hold_bad, 0);
    if (!st && ek < 0 && p >= 1) begin
      for (int i = 0; i < n_log; i++)
        if (!lg_wr[i] && lg_addr[i] == 8'h1E) begin
          if (lastp >= 0 && lg_cyc[i] - lastp != W + 1) gap_ok = 0;
          lastp = lg_cyc[i];
        end
      chk(gap_ok, "R4", "poll spacing", gap_ok, 1);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    #1;
    chk(cmd_done == 0 && cmd_error == 0 && cmd_rdata == 0 && rq_valid == 0,
        "R10", "reset outputs", {cmd_done, cmd_error, rq_valid}, 0);
    rst = 0;
    repeat (2) @(negedge clk);
    for (int wr = 0; wr < 2; wr++)
      for (int st = 0; st < 2; st++)
        for (int p = 0; p <= LIM + 1; p++)
          run_op(wr[0], 0, 16'h1234 + 16'(p * 16'h0F1D + st * 16'h8001 + wr * 16'h0707),
                 8'(8'hA5 ^ p), p, st[0], -1, -1);
    run_op(1, 1, 16'h0187, 8'hC0, 0, 0, -1, -1);
    run_op(1, 1, 16'hFFFF, 8'h3F, 2, 1, -1, -1);
    for (int wr = 0; wr < 2; wr++)
      for (int ek = 0; ek < 6; ek++)
        run_op(wr[0], 0, 16'h5A00 + 16'(ek), 8'(ek + 1), 1, 0, ek, -1);
    run_op(1, 0, 16'hBEEF, 8'h77, 2, 0, -1, 3);
    run_op(0, 0, 16'h0102, 8'h00, 1, 0, -1, 8);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule